// File: doc/BRIEF.md
# Receive Phase Sweep Controller

This block finds a working receive sampling phase for a high-speed card interface. When started, it steps a programmable delay line through all sixteen tap settings. At each tap it first reprograms the line through a clock-gating handshake. It then asks an external command engine to perform one tuning read, and records in a sixteen-bit mask whether that read succeeded.

After the sweep, a combinational selector picks a phase inside the widest passing window. The controller programs that phase into the line and keeps it as the saved phase. A mask in which every tap passes gives no information about where the data eye lies. In that case the controller asks for stronger output drive on the card and repeats the sweep. If any drive change was accepted, the drive setting is put back to its default before the final phase is programmed.

The command engine and the pattern comparison sit outside the block. The engine reports one pass bit per read. The block tells the engine how long the expected tuning pattern is for the bus width chosen at start. All interfaces are plain control handshakes: a request is held until it is answered, and no data stream crosses the block edge.

Top module: `rx_phase_sweep`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `cmd_req` and `drv_req` are low, and `saved_phase` and `final_phase` are 0.
- R2: One sweep issues exactly sixteen tuning reads, for phases 0 up to 15 in ascending order. During the read of phase p, `dl_code` holds the Gray code p XOR (p>>1), so the sequence is 0,1,3,2,6,7,5,4,C,D,F,E,A,B,9,8.
- R3: Each tap write follows this order. First the controller clears `dl_cdr_en` and `dl_clkout_en` and sets `dl_ext_en` and `dl_en`. It waits for `dl_clkout_sts` to read low, then changes `dl_code`, then raises `dl_clkout_en`. After `dl_clkout_sts` reads high, it sets `dl_cdr_en` and clears `dl_ext_en`. A tuning read is requested only in that final state.
- R4: If `dl_clkout_sts` stays low for `LOCK_TIMEOUT` cycles after `dl_clkout_en` rises, the run ends with `err` high, and no further reads or drive requests are made.
- R5: `cmd_blk_bytes` is 128 when `bus_8bit` was high at start, and 64 otherwise.
- R6: A phase is marked passing only when its `cmd_done` arrives with `cmd_pass` high.
- R7: When all sixteen phases pass, drive types 1, 2 and 3 are requested in turn through `drv_req`/`drv_type`. A rejected type (`drv_ack` with `drv_accept` low) moves on to the next type. An accepted type clears the mask and restarts the sweep. The type counter is not reset, so at most three restarts occur, and a final all-pass mask goes to the selector unchanged.
- R8: If any drive type was accepted during the run, drive type 0 is requested after the last sweep and before the final tap is programmed.
- R9: The selected phase lies in the longest run of consecutive passing phases. A run wraps from 15 to 0 when both pass and not every phase passes. On a tie, the run with the lowest start wins. With run length L, the offset into the run is floor(3L/4), minus one if that value is nonzero, counted modulo 16.
- R10: If no phase passes, `err` rises, `saved_phase` keeps its previous value, and the delay line is not reprogrammed.
- R11: On success, the selected phase is written to the line again, then `done` rises with `final_phase` and `saved_phase` equal to it. `done` and `err` are never high together, and both clear on the next accepted start.
- R12: A `start` pulse while `busy` is high is ignored.
- R13: `cmd_req` stays high until `cmd_done`, and `drv_req` stays high with a stable `drv_type` until `drv_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a tuning run when idle |
| bus_8bit | input | 1 | Bus width for this run: 1 = 8-bit, 0 = 4-bit |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run ended with a phase chosen |
| err | output | 1 | Run ended without a usable phase |
| final_phase | output | 4 | Phase chosen by the last selection |
| saved_phase | output | 4 | Last successfully programmed phase |
| dl_cdr_en | output | 1 | Delay line clock-data-recovery enable |
| dl_clkout_en | output | 1 | Delay line clock-output enable |
| dl_ext_en | output | 1 | Delay line external-recovery enable |
| dl_en | output | 1 | Delay line enable |
| dl_code | output | 4 | Gray-coded tap setting |
| dl_clkout_sts | input | 1 | Read-back of clock-output enable |
| cmd_req | output | 1 | Tuning read request |
| cmd_blk_bytes | output | 8 | Expected tuning pattern length in bytes |
| cmd_done | input | 1 | Tuning read finished (one-cycle pulse) |
| cmd_pass | input | 1 | Read completed without error and data matched |
| drv_req | output | 1 | Drive-strength change request |
| drv_type | output | 2 | Requested drive type |
| drv_ack | input | 1 | Drive request answered (one-cycle pulse) |
| drv_accept | input | 1 | Drive type was applied |

## Verification
A tap write takes at least five cycles from the controller entering programming to the first read request: the go cycle, the wait for low read-back, the code write, the clock-output raise, and the wait for high read-back. `cmd_req` rises one cycle after the programmer reports completion. The scoreboard compares `dl_code` at the first falling edge where `cmd_req` is seen high, which is the point where R2 and R3 are settled. `done` or `err` rises in the cycle after the final handshake, either the final programming completion, a timeout, or the selection step that finds an empty mask. The bench polls for that flag on falling edges and checks `final_phase`, `saved_phase` and `dl_code` only after it has risen. Drive types are compared at the cycle in which the responder acknowledges them.

// File: rtl/rx_sweep_pkg.sv
package rx_sweep_pkg;

  typedef enum logic [3:0] {
    T_IDLE, T_PGO, T_PWAIT, T_CMD, T_EVAL, T_DRV, T_REST, T_SEL, T_FGO, T_FWAIT
  } sweep_st_t;

  typedef enum logic [1:0] {
    P_IDLE, P_WLOW, P_SETCK, P_WHIGH
  } prog_st_t;

  // binary-reflected Gray code of a tap index
  function automatic logic [3:0] to_gray(input logic [3:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/dly_line_prog.sv
module dly_line_prog
  import rx_sweep_pkg::*;
#(
  parameter int CODE_W       = 4,
  parameter int LOCK_TIMEOUT = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CODE_W-1:0] code_in,
  input  logic              clkout_sts,
  output logic              cdr_en,
  output logic              clkout_en,
  output logic              ext_en,
  output logic              dll_en,
  output logic [CODE_W-1:0] code_out,
  output logic              done,
  output logic              err
);
  localparam int TW = $clog2(LOCK_TIMEOUT + 1);

  prog_st_t          st;
  logic [CODE_W-1:0] code_hold;
  logic [TW-1:0]     tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= P_IDLE;
      cdr_en    <= 1'b0;
      clkout_en <= 1'b0;
      ext_en    <= 1'b0;
      dll_en    <= 1'b0;
      code_out  <= '0;
      code_hold <= '0;
      tmr       <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (st)
        P_IDLE: if (go) begin
          // step 1: gate the output and hand control to the external path
          cdr_en    <= 1'b0;
          clkout_en <= 1'b0;
          ext_en    <= 1'b1;
          dll_en    <= 1'b1;
          code_hold <= code_in;
          st        <= P_WLOW;
        end
        P_WLOW: if (!clkout_sts) begin
          code_out <= code_hold;
          st       <= P_SETCK;
        end
        P_SETCK: begin
          clkout_en <= 1'b1;
          tmr       <= '0;
          st        <= P_WHIGH;
        end
        P_WHIGH: begin
          if (clkout_sts) begin
            cdr_en <= 1'b1;
            ext_en <= 1'b0;
            done   <= 1'b1;
            st     <= P_IDLE;
          end else if (tmr == TW'(LOCK_TIMEOUT - 1)) begin
            err <= 1'b1;
            st  <= P_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= P_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phase_window_pick.sv
module phase_window_pick #(
  parameter int NPH = 16
) (
  input  logic [NPH-1:0]         mask,
  output logic [$clog2(NPH)-1:0] sel,
  output logic                   any_pass
);
  localparam int PW = $clog2(NPH);
  localparam int CW = $clog2(NPH + 1);

  logic           all_pass;
  logic [CW-1:0]  run_len [NPH];

  assign all_pass = &mask;
  assign any_pass = |mask;

  // one run-length evaluator per candidate start position
  for (genvar gs = 0; gs < NPH; gs++) begin : g_run
    always_comb begin
      int  n;
      logic live;
      logic is_start;
      n    = 0;
      live = 1'b1;
      for (int k = 0; k < NPH; k++) begin
        if (live && mask[(gs + k) % NPH]) n = n + 1;
        else live = 1'b0;
      end
      is_start = mask[gs] &&
                 (!mask[(gs + NPH - 1) % NPH] || (all_pass && gs == 0));
      run_len[gs] = is_start ? CW'(n) : '0;
    end
  end

  always_comb begin
    int best_len;
    int best_start;
    int off;
    best_len   = 0;
    best_start = 0;
    for (int s = 0; s < NPH; s++) begin
      if (int'(run_len[s]) > best_len) begin
        best_len   = int'(run_len[s]);
        best_start = s;
      end
    end
    off = (best_len * 3) / 4;
    if (off != 0) off = off - 1;
    sel = PW'((best_start + off) % NPH);
  end

endmodule

// File: rtl/rx_phase_sweep.sv
module rx_phase_sweep
  import rx_sweep_pkg::*;
#(
  parameter int NPH          = 16,
  parameter int LOCK_TIMEOUT = 5000,
  parameter int DRV_MAX      = 3,
  parameter int BLK_NARROW   = 64,
  parameter int BLK_WIDE     = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       bus_8bit,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic [3:0] final_phase,
  output logic [3:0] saved_phase,
  output logic       dl_cdr_en,
  output logic       dl_clkout_en,
  output logic       dl_ext_en,
  output logic       dl_en,
  output logic [3:0] dl_code,
  input  logic       dl_clkout_sts,
  output logic       cmd_req,
  output logic [7:0] cmd_blk_bytes,
  input  logic       cmd_done,
  input  logic       cmd_pass,
  output logic       drv_req,
  output logic [1:0] drv_type,
  input  logic       drv_ack,
  input  logic       drv_accept
);
  localparam int PW = $clog2(NPH);
  localparam int DW = $clog2(DRV_MAX + 1);

  sweep_st_t       st;
  logic [PW-1:0]   phase;
  logic [NPH-1:0]  mask;
  logic [DW-1:0]   drv_try;
  logic [DW-1:0]   drv_type_q;
  logic            drv_chg;
  logic            bus8_q;
  logic [PW-1:0]   sel_q;
  logic [PW-1:0]   saved_q;
  logic            done_q;
  logic            err_q;

  logic            prog_go;
  logic [PW-1:0]   prog_code;
  logic            prog_done;
  logic            prog_err;
  logic [PW-1:0]   pick;
  logic            any_pass;

  assign prog_go   = (st == T_PGO) || (st == T_FGO);
  assign prog_code = to_gray((st == T_FGO) ? sel_q : phase);

  dly_line_prog #(
    .CODE_W       (PW),
    .LOCK_TIMEOUT (LOCK_TIMEOUT)
  ) u_prog (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (prog_go),
    .code_in    (prog_code),
    .clkout_sts (dl_clkout_sts),
    .cdr_en     (dl_cdr_en),
    .clkout_en  (dl_clkout_en),
    .ext_en     (dl_ext_en),
    .dll_en     (dl_en),
    .code_out   (dl_code),
    .done       (prog_done),
    .err        (prog_err)
  );

  phase_window_pick #(.NPH(NPH)) u_pick (
    .mask     (mask),
    .sel      (pick),
    .any_pass (any_pass)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= T_IDLE;
      phase      <= '0;
      mask       <= '0;
      drv_try    <= '0;
      drv_type_q <= '0;
      drv_chg    <= 1'b0;
      bus8_q     <= 1'b0;
      sel_q      <= '0;
      saved_q    <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      unique case (st)
        T_IDLE: if (start) begin
          phase   <= '0;
          mask    <= '0;
          drv_try <= '0;
          drv_chg <= 1'b0;
          bus8_q  <= bus_8bit;
          done_q  <= 1'b0;
          err_q   <= 1'b0;
          st      <= T_PGO;
        end
        T_PGO: st <= T_PWAIT;
        T_PWAIT: begin
          if (prog_err) begin
            err_q <= 1'b1;
            st    <= T_IDLE;
          end else if (prog_done) begin
            st <= T_CMD;
          end
        end
        T_CMD: if (cmd_done) begin
          mask[phase] <= cmd_pass;
          if (phase == PW'(NPH - 1)) st <= T_EVAL;
          else begin
            phase <= phase + 1'b1;
            st    <= T_PGO;
          end
        end
        T_EVAL: begin
          if ((&mask) && (drv_try < DW'(DRV_MAX))) begin
            drv_try    <= drv_try + 1'b1;
            drv_type_q <= drv_try + 1'b1;
            st         <= T_DRV;
          end else if (drv_chg) begin
            drv_type_q <= '0;
            st         <= T_REST;
          end else begin
            st <= T_SEL;
          end
        end
        T_DRV: if (drv_ack) begin
          if (drv_accept) begin
            drv_chg <= 1'b1;
            mask    <= '0;
            phase   <= '0;
            st      <= T_PGO;
          end else begin
            st <= T_EVAL;
          end
        end
        T_REST: if (drv_ack) st <= T_SEL;
        T_SEL: begin
          if (!any_pass) begin
            err_q <= 1'b1;
            st    <= T_IDLE;
          end else begin
            sel_q <= pick;
            st    <= T_FGO;
          end
        end
        T_FGO: st <= T_FWAIT;
        T_FWAIT: begin
          if (prog_err) begin
            err_q <= 1'b1;
            st    <= T_IDLE;
          end else if (prog_done) begin
            saved_q <= sel_q;
            done_q  <= 1'b1;
            st      <= T_IDLE;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  assign busy          = (st != T_IDLE);
  assign done          = done_q;
  assign err           = err_q;
  assign final_phase   = 4'(sel_q);
  assign saved_phase   = 4'(saved_q);
  assign cmd_req       = (st == T_CMD);
  assign cmd_blk_bytes = bus8_q ? 8'(BLK_WIDE) : 8'(BLK_NARROW);
  assign drv_req       = (st == T_DRV) || (st == T_REST);
  assign drv_type      = 2'(drv_type_q);

endmodule

// File: rtl/rx_phase_sweep_chk.sv
module rx_phase_sweep_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       dl_cdr_en,
  input logic       dl_clkout_en,
  input logic       dl_ext_en,
  input logic       dl_en,
  input logic [3:0] dl_code,
  input logic       dl_clkout_sts,
  input logic       cmd_req,
  input logic       cmd_done,
  input logic       drv_req,
  input logic [1:0] drv_type,
  input logic       drv_ack
);
  // R3: the tap code only moves while the output is gated and read back low
  p_code_when_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_code != $past(dl_code)) |-> (!dl_clkout_en && !$past(dl_clkout_sts)));

  // R3: clock output is re-enabled only after a low read-back
  p_clkout_after_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dl_clkout_en) |-> !$past(dl_clkout_sts));

  // R3: reads happen only with recovery handed back to the line
  p_read_when_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> (dl_cdr_en && !dl_ext_en && dl_clkout_en && dl_en));

  // R13: request holding
  p_cmd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_done) |=> cmd_req);

  p_drv_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_req && !drv_ack) |=> (drv_req && $stable(drv_type)));

  // R11: outcome flags exclusive
  p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R12: no requests leave an idle controller
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cmd_req && !drv_req));
endmodule

bind rx_phase_sweep rx_phase_sweep_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .err           (err),
  .dl_cdr_en     (dl_cdr_en),
  .dl_clkout_en  (dl_clkout_en),
  .dl_ext_en     (dl_ext_en),
  .dl_en         (dl_en),
  .dl_code       (dl_code),
  .dl_clkout_sts (dl_clkout_sts),
  .cmd_req       (cmd_req),
  .cmd_done      (cmd_done),
  .drv_req       (drv_req),
  .drv_type      (drv_type),
  .drv_ack       (drv_ack)
);

// File: tb/rx_phase_sweep_tb.sv
module rx_phase_sweep_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, start, bus_8bit;
  logic       busy, done, err;
  logic [3:0] final_phase, saved_phase, dl_code;
  logic       dl_cdr_en, dl_clkout_en, dl_ext_en, dl_en, dl_clkout_sts;
  logic       cmd_req, cmd_done, cmd_pass;
  logic [7:0] cmd_blk_bytes;
  logic       drv_req, drv_ack, drv_accept;
  logic [1:0] drv_type;

  rx_phase_sweep #(.LOCK_TIMEOUT(20)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_8bit(bus_8bit),
    .busy(busy), .done(done), .err(err),
    .final_phase(final_phase), .saved_phase(saved_phase),
    .dl_cdr_en(dl_cdr_en), .dl_clkout_en(dl_clkout_en), .dl_ext_en(dl_ext_en),
    .dl_en(dl_en), .dl_code(dl_code), .dl_clkout_sts(dl_clkout_sts),
    .cmd_req(cmd_req), .cmd_blk_bytes(cmd_blk_bytes), .cmd_done(cmd_done),
    .cmd_pass(cmd_pass), .drv_req(drv_req), .drv_type(drv_type),
    .drv_ack(drv_ack), .drv_accept(drv_accept)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] gray(input int p);
    return 4'(p ^ (p >> 1));
  endfunction

  function automatic int ungray(input logic [3:0] c);
    int r;
    r = int'(c);
    r = r ^ (r >> 1);
    r = r ^ (r >> 2);
    return r;
  endfunction

  // scenario state used by the responders
  logic [15:0] msk [4];
  bit          acc [4];
  bit          stuck;
  int          reads;
  int          sweep_no;
  logic [3:0]  code_q [$];
  int          drv_q  [$];

  // delay line read-back: follows clkout enable one half cycle later
  initial begin
    dl_clkout_sts = 1'b0;
    forever begin
      @(negedge clk);
      dl_clkout_sts = stuck ? 1'b0 : dl_clkout_en;
    end
  end

  // command engine: answers three cycles after a request
  initial begin
    int wait_n;
    bit hold;
    int ph;
    wait_n = 0; hold = 0;
    cmd_done = 1'b0; cmd_pass = 1'b0;
    forever begin
      @(negedge clk);
      cmd_done = 1'b0;
      if (cmd_req && !hold) begin
        wait_n++;
        if (wait_n == 3) begin
          ph = ungray(dl_code);
          if (ph == 0) sweep_no++;
          cmd_pass = msk[(sweep_no > 4) ? 3 : sweep_no - 1][ph];
          cmd_done = 1'b1;
          wait_n = 0;
          hold = 1;
          reads++;
        end
      end else if (!cmd_req) begin
        hold = 0;
      end
    end
  end

  // drive responder with scoreboard pop (R7, R8)
  initial begin
    int wait_n;
    bit hold;
    int e;
    wait_n = 0; hold = 0;
    drv_ack = 1'b0; drv_accept = 1'b0;
    forever begin
      @(negedge clk);
      drv_ack = 1'b0;
      if (drv_req && !hold) begin
        wait_n++;
        if (wait_n == 2) begin
          if (drv_q.size() == 0) chk(0, "R7 unexpected drive request", int'(drv_type), -1);
          else begin
            e = drv_q.pop_front();
            chk(int'(drv_type) == e, "R7/R8 drive type order", int'(drv_type), e);
          end
          drv_accept = acc[drv_type];
          drv_ack = 1'b1;
          wait_n = 0;
          hold = 1;
        end
      end else if (!drv_req) begin
        hold = 0;
      end
    end
  end

  // read monitor: pops the expected Gray code at each new read (R2, R3)
  initial begin
    logic prev;
    logic [3:0] e;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (cmd_req && !prev) begin
        if (code_q.size() == 0) chk(0, "R2 extra tuning read", int'(dl_code), -1);
        else begin
          e = code_q.pop_front();
          chk(dl_code == e, "R2 phase code", int'(dl_code), int'(e));
          chk(dl_cdr_en && !dl_ext_en && dl_clkout_en, "R3 line state at read",
              int'({dl_cdr_en, dl_ext_en, dl_clkout_en}), 5);
        end
      end
      prev = cmd_req;
    end
  end

  // driver: pushes expected codes, starts the run, waits for the outcome
  task automatic run_case(input bit bus8, input int nsweeps, input bit extra_start);
    int n;
    for (int s = 0; s < nsweeps; s++)
      for (int p = 0; p < 16; p++) code_q.push_back(gray(p));
    reads = 0;
    sweep_no = 0;
    bus_8bit = bus8;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(cmd_blk_bytes == (bus8 ? 8'd128 : 8'd64), "R5 pattern length",
        int'(cmd_blk_bytes), bus8 ? 128 : 64);
    if (extra_start) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (!(done || err) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(code_q.size() == 0, "R2 reads outstanding", code_q.size(), 0);
    chk(drv_q.size() == 0, "R7 drive requests outstanding", drv_q.size(), 0);
    chk(reads == 16 * nsweeps, "R2/R7 read count", reads, 16 * nsweeps);
  endtask

  task automatic expect_ok(input int sel, input string req);
    chk(done && !err, {req, " done flag"}, int'({done, err}), 2);
    chk(int'(final_phase) == sel, {req, " final phase"}, int'(final_phase), sel);
    chk(int'(saved_phase) == sel, "R11 saved phase", int'(saved_phase), sel);
    chk(dl_code == gray(sel), "R11 line reprogrammed", int'(dl_code), int'(gray(sel)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; bus_8bit = 1'b0; stuck = 0;
    reads = 0; sweep_no = 0;
    for (int i = 0; i < 4; i++) begin msk[i] = '0; acc[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !err, "R1 flags after reset", int'({busy, done, err}), 0);
    chk(!cmd_req && !drv_req, "R1 requests after reset", int'({cmd_req, drv_req}), 0);
    chk(saved_phase == 0 && final_phase == 0, "R1 phases after reset", int'(saved_phase), 0);

    // R9/R6: single window 4..7, length 4 -> offset 2 -> phase 6
    msk[0] = 16'h00F0;
    run_case(0, 1, 0);
    expect_ok(6, "R9 plain window");

    // R9: wrapping window 13..2 (len 6, offset 3 -> 0) beats 7..9, 8-bit bus
    msk[0] = 16'hE387;
    run_case(1, 1, 0);
    expect_ok(0, "R9 wrapped window");

    // R9 tie: runs 2..3 and 10..11, earliest wins -> 2; R12 start while busy
    msk[0] = 16'h0C0C;
    run_case(0, 1, 1);
    expect_ok(2, "R9 tie and R12 ignored start");

    // R7/R8: full pass, type 1 rejected, type 2 accepted, then restore 0
    msk[0] = 16'hFFFF; msk[1] = 16'h0FF0;
    acc[1] = 0; acc[2] = 1; acc[3] = 1;
    drv_q.push_back(1); drv_q.push_back(2); drv_q.push_back(0);
    run_case(0, 2, 0);
    expect_ok(9, "R7 retried sweep");

    // R7: every type accepted, every sweep full -> 3 restarts, len 16 -> 11
    msk[0] = 16'hFFFF; msk[1] = 16'hFFFF; msk[2] = 16'hFFFF; msk[3] = 16'hFFFF;
    acc[1] = 1; acc[2] = 1; acc[3] = 1;
    drv_q.push_back(1); drv_q.push_back(2); drv_q.push_back(3); drv_q.push_back(0);
    run_case(0, 4, 0);
    expect_ok(11, "R7 restart limit");

    // R8: all types rejected -> no restore request, single sweep
    acc[1] = 0; acc[2] = 0; acc[3] = 0;
    drv_q.push_back(1); drv_q.push_back(2); drv_q.push_back(3);
    run_case(0, 1, 0);
    expect_ok(11, "R8 no restore when unchanged");

    // R10: nothing passes
    msk[0] = 16'h0000;
    run_case(0, 1, 0);
    chk(err && !done, "R10 error flag", int'({done, err}), 1);
    chk(saved_phase == 4'd11, "R10 saved phase kept", int'(saved_phase), 11);
    chk(dl_code == 4'h8, "R10 no reprogramming", int'(dl_code), 8);

    // R6: a lone passing phase 9 is chosen
    msk[0] = 16'h0200;
    run_case(1, 1, 0);
    expect_ok(9, "R6 single pass");

    // R4: read-back never rises -> timeout error, no reads
    stuck = 1;
    msk[0] = 16'hFFFF;
    run_case(0, 0, 0);
    chk(err && !done, "R4 timeout error", int'({done, err}), 1);
    repeat (5) @(negedge clk);
    chk(!busy && !cmd_req, "R4 idle after timeout", int'({busy, cmd_req}), 0);
    stuck = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule